// File: doc/BRIEF.md
# Sequence-Serviced Watchdog Timer

This peripheral guards a system against software that stops making progress. A down-counter, clocked by a half-second time base, is loaded from a timeout field in the control register when the watchdog is switched on. Software must reload it regularly by writing a two-word key to the service register. If the count reaches zero, the block expires and requests either an internal chip reset or an active-low external reset. A pre-timeout interrupt can warn software a programmable number of half-seconds before expiry. A reset-cause register in the power-on reset domain records whether the last reset came from expiry or from a software request.

The time base is either the `tick_i` strobe used directly (`TICK_DIV` = 0 or 1) or `tick_i` used as a count enable for a `TICK_DIV` prescaler. A boot-time power-down counter is also included. Unless software writes 0 to the miscellaneous register, it pulses the external reset line low for one clock after `PD_TICKS` ticks.

The main sequencer has three states. ST_OFF moves to ST_RUN when the enable bit is set, loading WT+1. ST_RUN moves to ST_EXPIRED on the tick that takes the count from 1 to 0. ST_EXPIRED is left only through `rst_n`. The service decoder has two states. SV_IDLE moves to SV_ARMED on a service write of 0x5555. SV_ARMED reloads and returns to SV_IDLE on a write of 0xAAAA. It stays in SV_ARMED on another 0x5555 and falls back to SV_IDLE on any other value.

Top module: `seqwd_timer`

## Requirements
- R1: After reset the registers read as follows: control (offset 0x0) reads 0x0030, reset cause (0x4) reads 0x0000, interrupt control (0x6) reads 0x0004 and miscellaneous (0x8) reads 0x0001. The service register (0x2) reads 0. `irq_o` and `int_rst_o` are 0 and `ext_rst_n_o` is 1.
- R2: Control bits 15:8 hold WT. Once enabled, the block expires on the (WT+1)-th time-base tick after the count was loaded.
- R3: A service write of 0x5555 followed by a service write of 0xAAAA reloads the count to WT+1. A write of 0xAAAA that does not directly follow 0x5555 does not reload it, and neither does a sequence broken by any other value.
- R4: Control bit 2 enables the watchdog and is sticky: a later write of 0 neither clears it nor stops the count.
- R5: When control bit 0 is 1, counting is frozen while `lowpower_i` is high. Only the first control write after reset can change bit 0.
- R6: On expiry, control bit 3 = 0 raises `int_rst_o`, while bit 3 = 1 drives only `ext_rst_n_o` low. Both hold until `rst_n`.
- R7: Writing 0 to control bit 4 raises `int_rst_o` until `rst_n`; bit 4 always reads 1. Control bit 5 written 0 drives `ext_rst_n_o` low, and written 1 releases it.
- R8: Interrupt-control bits 7:0 set a pre-timeout distance. Bit 14 (status) sets on the tick that leaves the remaining count equal to that distance, and writing 1 to it clears it. Bit 15 enables it, and `irq_o` = bit 15 AND bit 14.
- R9: Reset-cause bit 1 sets on expiry and bit 0 sets on a software reset request, each clearing the other. Both survive `rst_n`, and only `por_n` clears them.
- R10: Unless the miscellaneous register is written with bit 0 = 0 first, `ext_rst_n_o` goes low for exactly one clock after the PD_TICKS-th tick following reset, and miscellaneous bit 0 then reads 0.
- R11: A WT write while running does not change the current count; the new value is used at the next reload.
- R12: With the enable bit never set, no number of ticks causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low system reset |
| por_n | input | 1 | Active-low power-on reset, also clears reset cause |
| tick_i | input | 1 | Half-second strobe, or prescaler enable when TICK_DIV > 1 |
| lowpower_i | input | 1 | Low-power indication for the freeze option |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| irq_o | output | 1 | Pre-timeout interrupt |
| int_rst_o | output | 1 | Internal reset request, active high |
| ext_rst_n_o | output | 1 | External reset output, active low |

## Verification
The bench builds the block with TICK_DIV = 0, so every half-second tick is a single strobe placed by the bench. This makes the expiry, the pre-timeout match and the freeze window exact to the tick. PD_TICKS = 6 brings the power-down pulse within a few ticks of reset, and the reset value 4 of the pre-timeout distance is kept. Small WT values such as 3 and 7 make every expiry reachable in under ten ticks.

// File: rtl/seqwd_pkg.sv
package seqwd_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_EXPIRED} run_st_t;
    typedef enum logic {SV_IDLE, SV_ARMED} svc_st_t;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_SVC   = 4'h2;
    localparam logic [3:0] OFS_CAUSE = 4'h4;
    localparam logic [3:0] OFS_ICTL  = 4'h6;
    localparam logic [3:0] OFS_MISC  = 4'h8;

    localparam logic [15:0] KEY_FIRST  = 16'h5555;
    localparam logic [15:0] KEY_SECOND = 16'hAAAA;
endpackage

// File: rtl/seqwd_svc.sv
module seqwd_svc
    import seqwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        reload_o
);
    svc_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SV_IDLE:  if (wr_i && data_i == KEY_FIRST) st_d = SV_ARMED;
            SV_ARMED: if (wr_i) st_d = (data_i == KEY_FIRST) ? SV_ARMED : SV_IDLE;
            default:  st_d = SV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SV_IDLE;
        else        st_q <= st_d;
    end

    assign reload_o = wr_i && (st_q == SV_ARMED) && (data_i == KEY_SECOND);

    // R3: a completed key pair leaves the decoder disarmed
    assert_key_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reload_o |=> st_q == SV_IDLE);
endmodule

// File: rtl/seqwd_pdown.sv
module seqwd_pdown #(
    parameter int PD_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clr_i,
    output logic en_o,
    output logic pulse_o
);
    localparam int PD_W = $clog2(PD_TICKS + 1);
    localparam logic [PD_W-1:0] PD_LAST = PD_W'(PD_TICKS - 1);

    logic [PD_W-1:0] cnt_q;
    logic            en_q, pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            en_q    <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (clr_i) begin
                en_q <= 1'b0;
            end else if (en_q && tick_i) begin
                if (cnt_q == PD_LAST) begin
                    pulse_q <= 1'b1;
                    en_q    <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign en_o    = en_q;
    assign pulse_o = pulse_q;

    // R10: the power-down pulse lasts one clock and never repeats
    assert_pd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> (!pulse_q && !en_q));
endmodule

// File: rtl/seqwd_timer.sv
module seqwd_timer
    import seqwd_pkg::*;
#(
    parameter int         TICK_DIV  = 0,
    parameter int         PD_TICKS  = 32,
    parameter logic [7:0] PRE_RESET = 8'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_n,
    input  logic        tick_i,
    input  logic        lowpower_i,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        irq_o,
    output logic        int_rst_o,
    output logic        ext_rst_n_o
);
    localparam int CNT_W = 9;
    localparam int DIV_W = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);

    // time base
    logic tick;
    generate
        if (TICK_DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      div_q <= '0;
                else if (tick_i) div_q <= (div_q == DIV_W'(TICK_DIV - 1)) ? '0 : div_q + 1'b1;
            end
            assign tick = tick_i && (div_q == DIV_W'(TICK_DIV - 1));
        end else begin : g_direct
            assign tick = tick_i;
        end
    endgenerate

    // register writes
    logic wr_ctrl, wr_svc, wr_ictl, wr_misc;
    assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
    assign wr_svc  = wr_en_i && (addr_i == OFS_SVC);
    assign wr_ictl = wr_en_i && (addr_i == OFS_ICTL);
    assign wr_misc = wr_en_i && (addr_i == OFS_MISC);

    logic [7:0] wt_q, pre_q;
    logic wda_q, wre_q, wde_q, frz_q, frz_lock_q, sw_rst_q, ie_q, is_q;
    logic tout_q, sft_q;
    logic svc_reload, pd_en, pd_pulse;

    run_st_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, load_val;
    logic             step, pre_hit, expire_evt;

    seqwd_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_svc),
        .data_i   (wdata_i),
        .reload_o (svc_reload)
    );

    seqwd_pdown #(.PD_TICKS(PD_TICKS)) u_pdown (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clr_i   (wr_misc && !wdata_i[0]),
        .en_o    (pd_en),
        .pulse_o (pd_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wt_q       <= '0;
            wda_q      <= 1'b1;
            wre_q      <= 1'b0;
            wde_q      <= 1'b0;
            frz_q      <= 1'b0;
            frz_lock_q <= 1'b0;
            sw_rst_q   <= 1'b0;
        end else if (wr_ctrl) begin
            wt_q  <= wdata_i[15:8];
            wda_q <= wdata_i[5];
            wre_q <= wdata_i[3];
            wde_q <= wde_q | wdata_i[2];
            if (!frz_lock_q) begin
                frz_q      <= wdata_i[0];
                frz_lock_q <= 1'b1;
            end
            if (!wdata_i[4]) sw_rst_q <= 1'b1;
        end
    end

    // sequencer
    assign load_val   = {1'b0, wt_q} + 9'd1;
    assign step       = (st_q == ST_RUN) && tick && !(frz_q && lowpower_i) && !svc_reload;
    assign pre_hit    = step && ((cnt_q - 9'd1) == {1'b0, pre_q});
    assign expire_evt = (st_q == ST_RUN) && (st_d == ST_EXPIRED);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:     if (wde_q) st_d = ST_RUN;
            ST_RUN:     if (step && cnt_q == 9'd1) st_d = ST_EXPIRED;
            ST_EXPIRED: st_d = ST_EXPIRED;
            default:    st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_OFF) begin
            cnt_q <= load_val;
        end else if (st_q == ST_RUN) begin
            if (svc_reload) cnt_q <= load_val;
            else if (step)  cnt_q <= cnt_q - 9'd1;
        end
    end

    // pre-timeout interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            is_q  <= 1'b0;
            pre_q <= PRE_RESET;
        end else begin
            if (wr_ictl) begin
                ie_q  <= wdata_i[15];
                pre_q <= wdata_i[7:0];
                if (wdata_i[14]) is_q <= 1'b0;
            end
            if (pre_hit) is_q <= 1'b1;
        end
    end

    // reset cause, power-on domain
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tout_q <= 1'b0;
            sft_q  <= 1'b0;
        end else if (expire_evt) begin
            tout_q <= 1'b1;
            sft_q  <= 1'b0;
        end else if (wr_ctrl && !wdata_i[4]) begin
            tout_q <= 1'b0;
            sft_q  <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        int_rst_o   = sw_rst_q || (st_q == ST_EXPIRED && !wre_q);
        ext_rst_n_o = !((st_q == ST_EXPIRED && wre_q) || !wda_q || pd_pulse);
        irq_o       = ie_q && is_q;
    end

    always_comb begin
        case (addr_i)
            OFS_CTRL:  rdata_o = {wt_q, 2'b00, wda_q, 1'b1, wre_q, wde_q, 1'b0, frz_q};
            OFS_CAUSE: rdata_o = {14'd0, tout_q, sft_q};
            OFS_ICTL:  rdata_o = {ie_q, is_q, 6'd0, pre_q};
            OFS_MISC:  rdata_o = {15'd0, pd_en};
            default:   rdata_o = 16'h0000;
        endcase
    end

    // R4: enable cannot be withdrawn
    assert_enable_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wde_q |=> wde_q);
    // R3: a reload restores WT+1
    assert_reload_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_reload && st_q == ST_RUN) |=> cnt_q == ({1'b0, $past(wt_q)} + 9'd1));
    // R2: expiry is final until system reset
    assert_expired_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_EXPIRED |=> st_q == ST_EXPIRED);
    // R2: count stays within WT+1 range
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 9'd256);
    // R5: frozen count does not move
    assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && frz_q && lowpower_i && !svc_reload) |=> $stable(cnt_q));
    // R8: status rises only at the programmed distance
    assert_pre_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_q) |-> cnt_q == {1'b0, pre_q});
    // R9: timeout cause persists until a software request or power-on reset
    assert_tout_keeps_R9: assert property (@(posedge clk) disable iff (!por_n)
        (tout_q && !(wr_ctrl && !wdata_i[4])) |=> tout_q);
endmodule

// File: tb/seqwd_timer_tb.sv
module seqwd_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0, tick_i = 1'b0, lowpower_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = 4'h0;
    logic [15:0] wdata_i = 16'h0;
    logic [15:0] rdata_o;
    logic        irq_o, int_rst_o, ext_rst_n_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seqwd_timer #(.TICK_DIV(0), .PD_TICKS(6), .PRE_RESET(8'd4)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_i(tick_i),
        .lowpower_i(lowpower_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
        .int_rst_o(int_rst_o), .ext_rst_n_o(ext_rst_n_o)
    );

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; por_n = 0; wr_en_i = 0; tick_i = 0; lowpower_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; por_n = 1;
    endtask

    task automatic sys_reset();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en_i = 1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1;
            @(negedge clk);
            tick_i = 0;
        end
    endtask

    task automatic setup();
        do_reset();
        wr(4'h8, 16'h0000);
    endtask

    task automatic enable(input logic [15:0] c);
        wr(4'h0, c);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
        rd(4'h4, d); chk("R1 cause", d, 16'h0000);
        rd(4'h6, d); chk("R1 ictl", d, 16'h0004);
        rd(4'h8, d); chk("R1 misc", d, 16'h0001);
        rd(4'h2, d); chk("R1 svc", d, 16'h0000);
        chk("R1 outs", {13'd0, irq_o, int_rst_o, ext_rst_n_o}, 16'h0001);
    endtask

    task automatic t_timeout_int();
        logic [15:0] d;
        setup();
        enable(16'h0334);
        tk(3); chk("R2 before expiry", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R2 R6 int reset", {14'd0, int_rst_o, ext_rst_n_o}, 16'h3);
        rd(4'h4, d); chk("R9 timeout cause", d, 16'h0002);
        sys_reset();
        chk("R6 released by rst_n", {15'd0, int_rst_o}, 16'h0);
        rd(4'h4, d); chk("R9 cause survives rst_n", d, 16'h0002);
        do_reset();
        rd(4'h4, d); chk("R9 cleared by por", d, 16'h0000);
    endtask

    task automatic t_timeout_ext();
        setup();
        enable(16'h033C);
        tk(4); chk("R6 ext only", {14'd0, int_rst_o, ext_rst_n_o}, 16'h0);
    endtask

    task automatic t_service();
        setup();
        enable(16'h0334);
        tk(2);
        wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        tk(3); chk("R3 reload holds off", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R3 expiry after reload", {15'd0, int_rst_o}, 16'h1);
        setup();
        enable(16'h0334);
        tk(2);
        wr(4'h2, 16'hAAAA); wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
        tk(1); chk("R3 bad sequence no reload", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R3 bad sequence expiry", {15'd0, int_rst_o}, 16'h1);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        setup();
        enable(16'h0334);
        wr(4'h0, 16'h0330);
        rd(4'h0, d); chk("R4 enable reads 1", d, 16'h0334);
        tk(4); chk("R4 still expires", {15'd0, int_rst_o}, 16'h1);
    endtask

    task automatic t_disabled();
        setup();
        tk(20); chk("R12 no reset when off", {14'd0, int_rst_o, ext_rst_n_o}, 16'h1);
    endtask

    task automatic t_suspend();
        logic [15:0] d;
        setup();
        enable(16'h0335);
        lowpower_i = 1;
        tk(10); chk("R5 frozen", {15'd0, int_rst_o}, 16'h0);
        lowpower_i = 0;
        tk(3); chk("R5 resume count", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R5 expiry after resume", {15'd0, int_rst_o}, 16'h1);
        setup();
        wr(4'h0, 16'h0330);
        enable(16'h0335);
        rd(4'h0, d); chk("R5 write once", d, 16'h0334);
        lowpower_i = 1;
        tk(4); chk("R5 no freeze without bit", {15'd0, int_rst_o}, 16'h1);
        lowpower_i = 0;
    endtask

    task automatic t_pretimeout();
        logic [15:0] d;
        setup();
        wr(4'h6, 16'h8002);
        enable(16'h0734);
        tk(5); chk("R8 no irq early", {15'd0, irq_o}, 16'h0);
        tk(1); chk("R8 irq at distance", {15'd0, irq_o}, 16'h1);
        rd(4'h6, d); chk("R8 status set", d, 16'hC002);
        wr(4'h6, 16'hC002);
        rd(4'h6, d); chk("R8 status cleared", d, 16'h8002);
        chk("R8 irq cleared", {15'd0, irq_o}, 16'h0);
    endtask

    task automatic t_swreset();
        logic [15:0] d;
        setup();
        wr(4'h0, 16'h0020);
        chk("R7 sw int reset", {14'd0, int_rst_o, ext_rst_n_o}, 16'h3);
        rd(4'h0, d); chk("R7 bit4 reads 1", d & 16'h0010, 16'h0010);
        rd(4'h4, d); chk("R9 sw cause", d, 16'h0001);
        sys_reset();
        chk("R7 int released", {15'd0, int_rst_o}, 16'h0);
        rd(4'h4, d); chk("R9 sw cause survives", d, 16'h0001);
        wr(4'h0, 16'h0010);
        chk("R7 ext asserted", {14'd0, int_rst_o, ext_rst_n_o}, 16'h0);
        wr(4'h0, 16'h0030);
        chk("R7 ext released", {15'd0, ext_rst_n_o}, 16'h1);
    endtask

    task automatic t_powerdown();
        logic [15:0] d;
        do_reset();
        tk(5); chk("R10 before pulse", {15'd0, ext_rst_n_o}, 16'h1);
        tk(1); chk("R10 pulse low", {15'd0, ext_rst_n_o}, 16'h0);
        @(negedge clk); chk("R10 pulse one clock", {15'd0, ext_rst_n_o}, 16'h1);
        rd(4'h8, d); chk("R10 misc after pulse", d, 16'h0000);
        setup();
        tk(8); chk("R10 disabled by write", {15'd0, ext_rst_n_o}, 16'h1);
    endtask

    task automatic t_wt_late();
        setup();
        enable(16'h0334);
        wr(4'h0, 16'h0734);
        tk(3); chk("R11 old count kept", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R11 old count expires", {15'd0, int_rst_o}, 16'h1);
        setup();
        enable(16'h0334);
        wr(4'h0, 16'h0734);
        wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        tk(7); chk("R11 new WT after reload", {15'd0, int_rst_o}, 16'h0);
        tk(1); chk("R11 new WT expiry", {15'd0, int_rst_o}, 16'h1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_timeout_int();
        t_timeout_ext();
        t_service();
        t_sticky();
        t_disabled();
        t_suspend();
        t_pretimeout();
        t_swreset();
        t_powerdown();
        t_wt_late();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end
endmodule